// File: doc/BRIEF.md
# Byte-Wide SPI Master with Flag Handshake

This block is a single-byte SPI master that hangs off a small processor register bus. Software programs a control register to pick the clock rate, clock polarity and sampling phase. It then writes one byte to the data register. The block loads that byte into a shift register and drives it out on MOSI, most significant bit first, while collecting MISO bits into the same register. When the eighth bit finishes, the received byte is copied into a receive buffer and a completion flag rises. If interrupts are enabled, the flag also raises an interrupt line.

The completion flag is a handshake. It drops only after a status read that saw it set, followed by a read of the data register. While the flag is pending and has not yet been acknowledged by a status read, transmit writes are refused and counted as collisions. A byte that completes while the flag is still pending leaves the old buffer in place and marks an overrun. A low level on the slave-select input while the block is an enabled master is a mode fault. It aborts any transfer, drops both the enable and master bits, and latches a fault flag.

Top module: `spi_master_ctrl`

## Requirements
- R1: Register addresses are 0 = control, 1 = status, 2 = data (a write loads the transmit byte, a read returns the receive buffer), and 3 reads as zero. Control bits are [7] interrupt enable, [6] enable, [5] rate bit 2, [4] master, [3] clock polarity, [2] clock phase, [1:0] rate bits 1:0. Status bits are [7] done flag, [6] write collision, [5] overrun, [4] mode fault, and [3:0] read zero. After reset every register reads 0, SCK is 0 and the interrupt line is 0.
- R2: The rate code {ctrl[5],ctrl[1:0]} gives an SCK period of 2^(code+1) system clocks. During one byte, SCK spends 8 half-periods away from its idle level. When no byte is in flight, SCK sits at the polarity bit's level.
- R3: A data write while enable=1, master=1 and SS high starts a byte. MOSI carries the byte MSB first. With phase 0, MISO is sampled on leading SCK edges; with phase 1, it is sampled on trailing edges. The byte sampled from MISO becomes the receive buffer.
- R4: The done flag sets when the eighth bit completes. The interrupt line equals done flag AND interrupt enable.
- R5: The done flag clears only when a data read follows a status read that found it set. A data read without that prior status read leaves it set. The same clearing data read also clears the collision and overrun flags.
- R6: While the done flag is set and no status read has acknowledged it, a data write starts no transfer and sets the collision flag.
- R7: A data write during a byte in flight sets the collision flag and leaves that byte's MOSI and MISO contents unchanged.
- R8: If a byte completes while the done flag is still set, the overrun flag sets and the receive buffer keeps its earlier value.
- R9: SS low while enable=1 and master=1 clears both bits on the next clock, sets the mode fault flag, and aborts any byte in flight so that SCK returns to idle with no completion. A later control write clears the mode fault flag.
- R10: A data write while enable or master is 0 starts no transfer and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select sense; low in master mode is a fault |

## Verification
The assertions check the cycle-level rules on every clock. The done flag cannot drop without a data read, and the receive buffer is frozen while the flag is pending. A locked-out write cannot start a byte, a mode fault drops the control bits and latches the fault on the next edge, and SCK only moves on divider ticks. The bench scenarios are needed for the serial behaviour itself: a slave model checks the bit order and sampling phase in all four clock modes, and the bench measures SCK timing for several rate codes. The scenarios also cover the ordering of the two-step clear, overrun keeping the earlier byte, and an aborted transfer that never completes.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_STAT = 2'd1,
    ADR_DATA = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  // control register bit positions
  localparam int C_IRQ_EN = 7;
  localparam int C_ENABLE = 6;
  localparam int C_RATE2  = 5;
  localparam int C_MASTER = 4;
  localparam int C_CPOL   = 3;
  localparam int C_CPHA   = 2;
  localparam int C_RATE1  = 1;
  localparam int C_RATE0  = 0;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CW = (1 << RATE_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = (CW'(1) << rate) - CW'(1);
    tick  = run && (cnt_q >= lim);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] load,
  input  logic          abort,
  input  logic          tick,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam int EW = $clog2(2 * DW);
  localparam logic [EW-1:0] LAST = EW'(2 * DW - 1);

  logic          busy_q, busy_d;
  logic [EW-1:0] edge_q, edge_d;
  logic [DW-1:0] sh_q, sh_d, shifted;
  logic          rxb_q, rxb_d;
  logic          ph_q, ph_d;
  logic          sample_now, shift_now, last;

  always_comb begin
    sample_now = (edge_q[0] == cpha);
    shift_now  = !sample_now && !(cpha && edge_q == '0);
    last       = (edge_q == LAST);
    shifted    = {sh_q[DW-2:0], rxb_q};
    rx_word    = cpha ? {sh_q[DW-2:0], miso} : shifted;
    done       = busy_q && tick && last && !abort;

    busy_d = busy_q;
    edge_d = edge_q;
    sh_d   = sh_q;
    rxb_d  = rxb_q;
    ph_d   = ph_q;
    if (abort) begin
      busy_d = 1'b0;
      edge_d = '0;
      ph_d   = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      edge_d = '0;
      ph_d   = 1'b0;
      sh_d   = load;
    end else if (busy_q && tick) begin
      ph_d   = !ph_q;
      edge_d = edge_q + EW'(1);
      if (sample_now) rxb_d = miso;
      if (shift_now)  sh_d  = shifted;
      if (last)       busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sh_q   <= '0;
      rxb_q  <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      edge_q <= edge_d;
      sh_q   <= sh_d;
      rxb_q  <= rxb_d;
      ph_q   <= ph_d;
    end
  end

  assign busy = busy_q;
  assign sck  = ph_q ^ cpol;
  assign mosi = sh_q[DW-1];

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> busy_q); // R3
  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick && !abort && !start) |=> $stable(ph_q)); // R2
endmodule

// File: rtl/spi_flags.sv
module spi_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] rx_word,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          tx_wr,
  input  logic          ready,
  input  logic          busy,
  input  logic          fault,
  input  logic          ctrl_wr,
  output logic          tx_accept,
  output logic          spif,
  output logic          armed,
  output logic          wcol,
  output logic          ovr,
  output logic          modf,
  output logic [DW-1:0] rxbuf
);
  logic          spif_q, spif_d, armed_q, armed_d;
  logic          wcol_q, wcol_d, ovr_q, ovr_d, modf_q, modf_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          spif_clr, keep_old, lock;

  always_comb begin
    spif_clr  = data_rd && armed_q;
    keep_old  = spif_q && !spif_clr;
    lock      = spif_q && !armed_q;
    tx_accept = tx_wr && ready && !busy && !lock;

    spif_d  = done || keep_old;
    armed_d = (stat_rd && spif_q) || (armed_q && !data_rd);
    wcol_d  = (tx_wr && ready && (busy || lock)) || (wcol_q && !spif_clr);
    ovr_d   = (done && keep_old) || (ovr_q && !spif_clr);
    modf_d  = fault || (modf_q && !ctrl_wr);
    buf_d   = (done && !keep_old) ? rx_word : buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif_q  <= 1'b0;
      armed_q <= 1'b0;
      wcol_q  <= 1'b0;
      ovr_q   <= 1'b0;
      modf_q  <= 1'b0;
      buf_q   <= '0;
    end else begin
      spif_q  <= spif_d;
      armed_q <= armed_d;
      wcol_q  <= wcol_d;
      ovr_q   <= ovr_d;
      modf_q  <= modf_d;
      buf_q   <= buf_d;
    end
  end

  assign spif  = spif_q;
  assign armed = armed_q;
  assign wcol  = wcol_q;
  assign ovr   = ovr_q;
  assign modf  = modf_q;
  assign rxbuf = buf_q;

  AST_SPIF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (spif_q && !data_rd) |=> spif_q); // R5
  AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (spif_q && !data_rd) |=> $stable(buf_q)); // R8
  AST_OVR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && spif_q && !data_rd) |=> ovr_q); // R8
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl #(
  parameter int RATE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  input  logic       ss_n
);
  import spi_pkg::*;
  localparam int DW = BYTE_W;

  logic [DW-1:0]     ctrl_q, ctrl_d;
  logic              ctrl_wr, stat_rd, data_rd, tx_wr;
  logic              en_mst, active, fault, abort;
  logic [RATE_W-1:0] rate;
  logic              tick, busy, done, tx_accept;
  logic              spif, armed, wcol, ovr, modf;
  logic [DW-1:0]     rx_word, rxbuf;

  always_comb begin
    ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
    stat_rd = bus_rd && (bus_addr == ADR_STAT);
    data_rd = bus_rd && (bus_addr == ADR_DATA);
    tx_wr   = bus_wr && (bus_addr == ADR_DATA);
    en_mst  = ctrl_q[C_ENABLE] && ctrl_q[C_MASTER];
    fault   = en_mst && !ss_n;
    active  = en_mst && ss_n;
    abort   = !active;
    rate    = RATE_W'({ctrl_q[C_RATE2], ctrl_q[C_RATE1], ctrl_q[C_RATE0]});

    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata;
    if (fault) begin
      ctrl_d[C_ENABLE] = 1'b0;
      ctrl_d[C_MASTER] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  spi_clk_div #(.RATE_W(RATE_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .rate (rate),
    .tick (tick)
  );

  spi_shifter #(.DW(DW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tx_accept),
    .load   (bus_wdata),
    .abort  (abort),
    .tick   (tick),
    .cpol   (ctrl_q[C_CPOL]),
    .cpha   (ctrl_q[C_CPHA]),
    .miso   (miso),
    .busy   (busy),
    .sck    (sck),
    .mosi   (mosi),
    .done   (done),
    .rx_word(rx_word)
  );

  spi_flags #(.DW(DW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .rx_word  (rx_word),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .tx_wr    (tx_wr),
    .ready    (active),
    .busy     (busy),
    .fault    (fault),
    .ctrl_wr  (ctrl_wr),
    .tx_accept(tx_accept),
    .spif     (spif),
    .armed    (armed),
    .wcol     (wcol),
    .ovr      (ovr),
    .modf     (modf),
    .rxbuf    (rxbuf)
  );

  always_comb begin
    unique case (bus_addr)
      ADR_CTRL: bus_rdata = ctrl_q;
      ADR_STAT: bus_rdata = {spif, wcol, ovr, modf, 4'b0000};
      ADR_DATA: bus_rdata = rxbuf;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = spif && ctrl_q[C_IRQ_EN];

  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!ctrl_q[C_ENABLE] && !ctrl_q[C_MASTER] && modf)); // R9
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && spif && !armed && !busy) |=> !busy); // R6
  AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_mst && !busy) |=> !busy); // R10
endmodule

// File: tb/sim_spi_master_ctrl.sv
`timescale 1ns/1ps
module sim_spi_master_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, sck, mosi, miso, ss_n = 1'b1;

  int checks = 0, fails = 0;

  // slave model state
  logic [7:0] sl_sh = 8'd0, sl_cap = 8'd0;
  int         sl_e = 0;
  logic       cur_cpol = 1'b0, cur_cpha = 1'b0;
  int         away = 0;

  always #2 clk = ~clk;

  spi_master_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  assign miso = sl_sh[7];

  always @(sck) begin
    if ((sl_e % 2) == int'(cur_cpha)) sl_cap = {sl_cap[6:0], mosi};
    else if (!(cur_cpha && sl_e == 0)) sl_sh = {sl_sh[6:0], 1'b0};
    sl_e = sl_e + 1;
  end

  always @(negedge clk) if (sck != cur_cpol) away = away + 1;

  function automatic logic [7:0] mk_ctrl(input logic ie, input logic en,
      input logic ms, input logic cp, input logic ch, input logic [2:0] r);
    return {ie, en, r[2], ms, cp, ch, r[1:0]};
  endfunction

  function automatic int half_of(input logic [2:0] r);
    return 1 << r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic setup(input logic ie, input logic cp, input logic ch, input logic [2:0] r);
    bus_write(2'd0, mk_ctrl(ie, 1'b1, 1'b1, cp, ch, r));
    cur_cpol = cp; cur_cpha = ch;
  endtask

  task automatic arm_slave(input logic [7:0] sl);
    sl_sh = sl; sl_cap = 8'd0; sl_e = 0; away = 0;
  endtask

  task automatic wait_done(input int half);
    repeat (16 * half + 8) @(negedge clk);
  endtask

  // full transfer with the two-step clear
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input logic cp,
      input logic ch, input logic [2:0] r, input logic ie);
    logic [7:0] v;
    setup(ie, cp, ch, r);
    arm_slave(sl);
    bus_write(2'd2, tx);
    wait_done(half_of(r));
    chk("R4 irq", irq, ie);
    chk("R2 sck half-periods away", away, 8 * half_of(r));
    chk("R2 sck idle", sck, cp);
    bus_read(2'd1, v);
    chk("R4 done flag", v, 8'h80);
    bus_read(2'd2, v);
    chk("R3 rx byte", v, sl);
    chk("R3 mosi byte", sl_cap, tx);
    bus_read(2'd1, v);
    chk("R5 cleared", v, 8'h00);
    chk("R4 irq low", irq, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sck reset", sck, 1'b0);
    chk("R1 irq reset", irq, 1'b0);
    rst_n = 1'b1;
    bus_read(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    bus_read(2'd1, v); chk("R1 stat reset", v, 8'h00);
    bus_read(2'd2, v); chk("R1 data reset", v, 8'h00);
    bus_read(2'd3, v); chk("R1 addr3 zero", v, 8'h00);
    bus_write(2'd0, 8'hA5); bus_read(2'd0, v); chk("R1 ctrl rw", v, 8'hA5);

    // R10: disabled write does nothing
    bus_write(2'd0, 8'h00); cur_cpol = 1'b0; arm_slave(8'h00);
    bus_write(2'd2, 8'h3C);
    repeat (20) @(negedge clk);
    chk("R10 no sck", away, 0);
    bus_read(2'd1, v); chk("R10 no flag", v, 8'h00);

    // directed: all four modes, extreme rates
    xfer(8'hA5, 8'h5A, 1'b0, 1'b0, 3'd0, 1'b1);
    xfer(8'h81, 8'h7E, 1'b0, 1'b1, 3'd1, 1'b0);
    xfer(8'hF0, 8'h0F, 1'b1, 1'b0, 3'd2, 1'b1);
    xfer(8'h01, 8'h80, 1'b1, 1'b1, 3'd7, 1'b0);

    // R5: data read without status read keeps flag
    setup(1'b1, 1'b0, 1'b0, 3'd0); arm_slave(8'h33);
    bus_write(2'd2, 8'h11); wait_done(1);
    bus_read(2'd2, v); chk("R5 data early", v, 8'h33);
    chk("R5 irq still set", irq, 1'b1);
    // R6: lockout before status read
    arm_slave(8'h00);
    bus_write(2'd2, 8'h99);
    repeat (20) @(negedge clk);
    chk("R6 no transfer", away, 0);
    bus_read(2'd1, v); chk("R6 collision", v, 8'hC0);
    bus_read(2'd2, v); chk("R6 buffer", v, 8'h33);
    bus_read(2'd1, v); chk("R5 all cleared", v, 8'h00);

    // R8: overrun after acknowledge, new byte while flag set
    setup(1'b0, 1'b0, 1'b1, 3'd1); arm_slave(8'h44);
    bus_write(2'd2, 8'h22); wait_done(2);
    bus_read(2'd1, v);
    arm_slave(8'h66);
    bus_write(2'd2, 8'h77); wait_done(2);
    chk("R8 second byte sent", sl_cap, 8'h77);
    bus_read(2'd1, v); chk("R8 overrun", v, 8'hA0);
    bus_read(2'd2, v); chk("R8 old kept", v, 8'h44);
    bus_read(2'd1, v); chk("R8 cleared", v, 8'h00);

    // R7: collision during busy
    setup(1'b0, 1'b0, 1'b0, 3'd3); arm_slave(8'hC3);
    bus_write(2'd2, 8'h96);
    repeat (10) @(negedge clk);
    bus_write(2'd2, 8'h00);
    wait_done(8);
    chk("R7 tx unchanged", sl_cap, 8'h96);
    bus_read(2'd1, v); chk("R7 collision", v, 8'hC0);
    bus_read(2'd2, v); chk("R7 rx unchanged", v, 8'hC3);
    bus_read(2'd1, v); chk("R7 cleared", v, 8'h00);

    // R9: mode fault aborts a transfer
    setup(1'b0, 1'b1, 1'b0, 3'd3); arm_slave(8'h12);
    bus_write(2'd2, 8'h34);
    repeat (20) @(negedge clk);
    ss_n = 1'b0; @(negedge clk); ss_n = 1'b1;
    @(negedge clk);
    chk("R9 sck idle", sck, 1'b1);
    repeat (200) @(negedge clk);
    bus_read(2'd1, v); chk("R9 fault flag", v, 8'h10);
    bus_read(2'd0, v); chk("R9 bits dropped", v, mk_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3));
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, v); chk("R9 fault cleared", v, 8'h00);

    // random transfers
    for (int i = 0; i < 24; i++) begin
      logic [7:0] tx, sl;
      logic [2:0] r;
      logic       cp, ch, ie;
      tx = 8'($urandom); sl = 8'($urandom);
      r = 3'($urandom % 5);
      cp = 1'($urandom); ch = 1'($urandom); ie = 1'($urandom);
      xfer(tx, sl, cp, ch, r, ie);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule